// File: doc/BRIEF.md
# Flash Erase/Program Timing Sequencer

This block is the command engine of an embedded flash controller. Software writes a control word that names one operation: mass erase, page erase, program, reference-cell erase or trim recall. The engine then runs the flash macro through three timed phases. These are a short setup delay, the main pulse and a non-volatile hold. Each phase length is a cycle count taken from packed timing registers. While the operation runs, a busy status bit is set. At the end the operation bit clears itself. A program operation also moves the address register forward by the number of bytes held in the program buffer, so the next chunk can be programmed without rewriting the address.

The sequencer is a four-state machine. **IDLE** waits for a request. The transition *start* (a control write while idle with at least one operation bit set) enters **SETUP**. The transition *setup_done* enters **PULSE**. The transition *pulse_done* enters **HOLD**. The transition *hold_done* returns to **IDLE**, where it clears busy and the operation bits and, after a program, advances the address. On entry to each phase a down-counter is loaded from that phase's field. A phase lasts N cycles for a field value N, and a value of 0 is treated as 1.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset, every register reads 0, busy is 0 and all macro strobes and `fl_op` are 0.
- R2: Register indices are 0 control, 1 timing0, 2 timing1, 3 timing2, 4 address, 5 buffer index and 6 status. Fields are placed as follows, and unused bits read 0:
  - timing0 holds read wait states in [5:0] and hold cycles in [31:16].
  - timing1 holds erase cycles in [23:0].
  - timing2 holds program cycles in [15:0], cycles per 100 ns in [23:16] and cycles per 10 ns in [27:24].
  - The buffer index holds 6 bits.
  - `rd_wait` equals timing0[5:0].
- R3: Control bits [7:3] request, in order: mass erase, page erase, program, reference erase and recall. A control write while idle with any of these bits set raises busy (status bit 0) from the next cycle, and busy stays high for max(T,1)+max(M,1)+max(H,1) cycles.
- R4: An operation asserts `fl_setup` for max(T,1) cycles, then `fl_pulse` for max(M,1) cycles, then `fl_hold` for max(H,1) cycles. These strobes appear in that order, and at most one is high at a time. T is the 10 ns field and H is the hold field.
- R5: M is chosen by operation:
  - the erase field for mass erase, page erase and reference erase;
  - the program field for program;
  - the 100 ns field for recall.
- R6: When several operation bits are written together, only the lowest-numbered one runs. While running, the control register shows only that bit, and `fl_op` shows it one-hot with bit 0 meaning mass erase.
- R7: A control write made while busy does not start or change an operation.
- R8: When the operation finishes, control bits [7:3] read 0 and `fl_op` returns to 0. Sleep (bit 0) and auto-program (bit 8) keep their written values and drive `sleep_mode` and `auto_prog`.
- R9: When a program operation finishes, the address register increases by the buffer index. Other operations leave it unchanged.
- R10: During a page erase, `fl_addr` is the address rounded down to a 4096-byte page. Otherwise it is the address register.
- R11: Address and buffer index writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register index for the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_idx | input | 3 | Register index for the read |
| reg_rd_data | output | 32 | Read data, combinational |
| busy | output | 1 | Operation in progress |
| fl_op | output | 5 | One-hot active operation |
| fl_setup | output | 1 | Setup phase strobe |
| fl_pulse | output | 1 | Main pulse strobe |
| fl_hold | output | 1 | Hold phase strobe |
| fl_addr | output | ADDR_W | Address presented to the macro |
| rd_wait | output | 6 | Read wait states |
| sleep_mode | output | 1 | Sleep mode bit |
| auto_prog | output | 1 | Auto-program bit |

## Verification
The hardest cases to reach from the ports are the phase boundaries where a field is 0 or 1. Each of these collapses a phase to a single cycle. A design that counts off by one, or skips a zero-length phase, still looks correct with larger values. The bench therefore sweeps every operation against setup and hold fields of 0, 1 and 2 and several pulse values. It gives the erase, program and 100 ns fields different values, so a wrong count selection changes the measured pulse length. Busy-time writes are placed one cycle after the start, when the engine is in its setup phase.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_PULSE = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_t;

    localparam int NUM_OPS     = 5;
    localparam int OP_MASS     = 0;
    localparam int OP_PAGE     = 1;
    localparam int OP_PROG     = 2;
    localparam int OP_REF      = 3;
    localparam int OP_RECALL   = 4;

    localparam int CTRL_SLEEP  = 0;
    localparam int CTRL_OP_LSB = 3;
    localparam int CTRL_AUTO   = 8;

    localparam int CNT_W       = 24;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_TIM0  = 3'd1;
    localparam logic [2:0] REG_TIM1  = 3'd2;
    localparam logic [2:0] REG_TIM2  = 3'd3;
    localparam logic [2:0] REG_ADDR  = 3'd4;
    localparam logic [2:0] REG_PBIDX = 3'd5;
    localparam logic [2:0] REG_STAT  = 3'd6;

endpackage

// File: rtl/flseq_arbiter.sv
module flseq_arbiter #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pri
            assign seen[i+1] = seen[i] | req[i];
            assign grant[i]  = req[i] & ~seen[i];
        end
    endgenerate
endmodule

// File: rtl/flseq_phase_timer.sv
module flseq_phase_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/flseq_fsm.sv
module flseq_fsm
    import flseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       phase_last,
    output seq_state_t state,
    output seq_state_t state_nx,
    output logic       load,
    output logic       done
);
    seq_state_t state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        load     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_SETUP;
                    load     = 1'b1;
                end
            end
            ST_SETUP: begin
                if (phase_last) begin
                    state_nx = ST_PULSE;
                    load     = 1'b1;
                end
            end
            ST_PULSE: begin
                if (phase_last) begin
                    state_nx = ST_HOLD;
                    load     = 1'b1;
                end
            end
            ST_HOLD: begin
                if (phase_last) begin
                    state_nx = ST_IDLE;
                    done     = 1'b1;
                end
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
    import flseq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_BYTES = 4096,
    parameter int PB_MAX     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_wr_idx,
    input  logic [31:0]       reg_wr_data,
    input  logic [2:0]        reg_rd_idx,
    output logic [31:0]       reg_rd_data,
    output logic              busy,
    output logic [4:0]        fl_op,
    output logic              fl_setup,
    output logic              fl_pulse,
    output logic              fl_hold,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [5:0]        rd_wait,
    output logic              sleep_mode,
    output logic              auto_prog
);
    localparam int PBI_W = $clog2(PB_MAX + 1);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'(PAGE_BYTES - 1);

    logic [5:0]          wait_q;
    logic [15:0]         nvh_q;
    logic [23:0]         erase_q;
    logic [15:0]         prog_q;
    logic [7:0]          c100_q;
    logic [3:0]          c10_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [PBI_W-1:0]    pbi_q;
    logic [NUM_OPS-1:0]  op_q;
    logic                sleep_q;
    logic                auto_q;

    logic [NUM_OPS-1:0]  req;
    logic [NUM_OPS-1:0]  grant;
    logic                wr_ctrl;
    logic                start;
    logic                load;
    logic                done;
    logic                phase_last;
    logic [CNT_W-1:0]    main_cnt;
    logic [CNT_W-1:0]    load_val;
    seq_state_t          state;
    seq_state_t          state_nx;

    assign req     = reg_wr_data[CTRL_OP_LSB +: NUM_OPS];
    assign wr_ctrl = reg_wr && (reg_wr_idx == REG_CTRL);
    assign start   = wr_ctrl && (state == ST_IDLE) && (|req);

    flseq_arbiter #(.N(NUM_OPS)) i_arb (
        .req   (req),
        .grant (grant)
    );

    flseq_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .phase_last (phase_last),
        .state      (state),
        .state_nx   (state_nx),
        .load       (load),
        .done       (done)
    );

    flseq_phase_timer #(.CNT_W(CNT_W)) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (phase_last)
    );

    always_comb begin
        if (op_q[OP_PROG]) begin
            main_cnt = CNT_W'(prog_q);
        end else if (op_q[OP_RECALL]) begin
            main_cnt = CNT_W'(c100_q);
        end else begin
            main_cnt = CNT_W'(erase_q);
        end
    end

    always_comb begin
        unique case (state_nx)
            ST_SETUP: load_val = CNT_W'(c10_q);
            ST_PULSE: load_val = main_cnt;
            ST_HOLD:  load_val = CNT_W'(nvh_q);
            default:  load_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q  <= '0;
            nvh_q   <= '0;
            erase_q <= '0;
            prog_q  <= '0;
            c100_q  <= '0;
            c10_q   <= '0;
            addr_q  <= '0;
            pbi_q   <= '0;
            op_q    <= '0;
            sleep_q <= 1'b0;
            auto_q  <= 1'b0;
        end else begin
            if (reg_wr) begin
                unique case (reg_wr_idx)
                    REG_CTRL: begin
                        sleep_q <= reg_wr_data[CTRL_SLEEP];
                        auto_q  <= reg_wr_data[CTRL_AUTO];
                    end
                    REG_TIM0: begin
                        wait_q <= reg_wr_data[5:0];
                        nvh_q  <= reg_wr_data[31:16];
                    end
                    REG_TIM1: erase_q <= reg_wr_data[23:0];
                    REG_TIM2: begin
                        prog_q <= reg_wr_data[15:0];
                        c100_q <= reg_wr_data[23:16];
                        c10_q  <= reg_wr_data[27:24];
                    end
                    REG_ADDR: begin
                        if (state == ST_IDLE) addr_q <= reg_wr_data[ADDR_W-1:0];
                    end
                    REG_PBIDX: begin
                        if (state == ST_IDLE) pbi_q <= reg_wr_data[PBI_W-1:0];
                    end
                    default: ;
                endcase
            end
            if (start) begin
                op_q <= grant;
            end else if (done) begin
                op_q <= '0;
                if (op_q[OP_PROG]) addr_q <= addr_q + ADDR_W'(pbi_q);
            end
        end
    end

    always_comb begin
        reg_rd_data = '0;
        unique case (reg_rd_idx)
            REG_CTRL: begin
                reg_rd_data[CTRL_SLEEP]                  = sleep_q;
                reg_rd_data[CTRL_OP_LSB +: NUM_OPS]      = op_q;
                reg_rd_data[CTRL_AUTO]                   = auto_q;
            end
            REG_TIM0:  reg_rd_data = {nvh_q, 10'd0, wait_q};
            REG_TIM1:  reg_rd_data = {8'd0, erase_q};
            REG_TIM2:  reg_rd_data = {4'd0, c10_q, c100_q, prog_q};
            REG_ADDR:  reg_rd_data[ADDR_W-1:0] = addr_q;
            REG_PBIDX: reg_rd_data[PBI_W-1:0]  = pbi_q;
            REG_STAT:  reg_rd_data[0] = (state != ST_IDLE);
            default:   reg_rd_data = '0;
        endcase
    end

    always_comb begin
        busy       = (state != ST_IDLE);
        fl_setup   = (state == ST_SETUP);
        fl_pulse   = (state == ST_PULSE);
        fl_hold    = (state == ST_HOLD);
        fl_op      = op_q;
        fl_addr    = op_q[OP_PAGE] ? (addr_q & PAGE_MASK) : addr_q;
        rd_wait    = wait_q;
        sleep_mode = sleep_q;
        auto_prog  = auto_q;
    end
endmodule

// File: rtl/flseq_checker.sv
module flseq_checker #(
    parameter int ADDR_W = 20,
    parameter int PBI_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [4:0]        fl_op,
    input logic              fl_setup,
    input logic              fl_pulse,
    input logic              fl_hold,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [PBI_W-1:0]  pbi
);
    // R4
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_setup, fl_pulse, fl_hold}));

    // R4
    pulse_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_pulse) |-> $past(fl_setup));

    // R4
    hold_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_hold) |-> $past(fl_pulse));

    // R6
    op_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(fl_op) == 1));

    // R8
    op_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fl_op == '0));

    // R7
    op_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fl_op));

    // R11
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fl_addr));

    // R9
    addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(fl_op[2])) |-> (fl_addr == $past(fl_addr) + ADDR_W'($past(pbi))));
endmodule

bind flash_op_sequencer flseq_checker #(.ADDR_W(ADDR_W), .PBI_W(PBI_W)) i_flseq_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .fl_op    (fl_op),
    .fl_setup (fl_setup),
    .fl_pulse (fl_pulse),
    .fl_hold  (fl_hold),
    .fl_addr  (fl_addr),
    .pbi      (pbi_q)
);

// File: tb/test_flash_op_sequencer.sv
module test_flash_op_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_wr_idx = '0;
    logic [31:0]       reg_wr_data = '0;
    logic [2:0]        reg_rd_idx = '0;
    logic [31:0]       reg_rd_data;
    logic              busy;
    logic [4:0]        fl_op;
    logic              fl_setup, fl_pulse, fl_hold;
    logic [ADDR_W-1:0] fl_addr;
    logic [5:0]        rd_wait;
    logic              sleep_mode, auto_prog;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_op_sequencer #(.ADDR_W(ADDR_W)) i_flash_op_sequencer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wr_idx(reg_wr_idx),
        .reg_wr_data(reg_wr_data), .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
        .busy(busy), .fl_op(fl_op), .fl_setup(fl_setup), .fl_pulse(fl_pulse),
        .fl_hold(fl_hold), .fl_addr(fl_addr), .rd_wait(rd_wait),
        .sleep_mode(sleep_mode), .auto_prog(auto_prog)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] data);
        reg_wr = 1'b1; reg_wr_idx = idx; reg_wr_data = data;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] val);
        reg_rd_idx = idx;
        #1;
        val = reg_rd_data;
    endtask

    // Starts an operation and measures the phase lengths from the next cycle on.
    task automatic run_op(input int opbit, input logic [31:0] extra,
                          output int ns, output int np, output int nh,
                          output int nb, output bit order_ok);
        int ph;
        ns = 0; np = 0; nh = 0; nb = 0; order_ok = 1'b1; ph = 0;
        wr(3'd0, (32'd1 << (opbit + 3)) | extra);
        while (busy && nb < 2000) begin
            nb++;
            if (fl_setup) begin
                ns++; if (ph != 0) order_ok = 1'b0;
            end else if (fl_pulse) begin
                np++; if (ph == 2) order_ok = 1'b0; ph = 1;
            end else if (fl_hold) begin
                nh++; if (ph == 0) order_ok = 1'b0; ph = 2;
            end else begin
                order_ok = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    function automatic int atleast1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int ns, np, nh, nb;
        bit ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 7; i++) begin
            rd(3'(i), v);
            chk(v == 0, "R1 reg reset", v, 0);
        end
        chk({busy, fl_setup, fl_pulse, fl_hold, fl_op} == 0, "R1 outputs reset",
            {busy, fl_setup, fl_pulse, fl_hold, fl_op}, 0);

        // R2 field masking
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); chk(v == 32'hFFFF_003F, "R2 timing0", v, 32'hFFFF_003F);
        chk(rd_wait == 6'h3F, "R2 rd_wait", rd_wait, 6'h3F);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk(v == 32'h00FF_FFFF, "R2 timing1", v, 32'h00FF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); chk(v == 32'h0FFF_FFFF, "R2 timing2", v, 32'h0FFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); chk(v == 32'h3F, "R2 buffer index", v, 32'h3F);
        wr(3'd1, 32'h0000_0015); chk(rd_wait == 6'h15, "R2 rd_wait value", rd_wait, 6'h15);

        // R8 sleep/auto bits stored without starting anything
        wr(3'd0, 32'h101); rd(3'd0, v);
        chk(v == 32'h101, "R8 ctrl keep bits", v, 32'h101);
        chk(sleep_mode && auto_prog && !busy, "R8 sleep/auto pins", {sleep_mode, auto_prog, busy}, 3'b110);
        wr(3'd0, 32'h0);
        wr(3'd5, 32'h0);

        // R3 R4 R5 sweep over operation, setup, hold and pulse values
        for (int op = 0; op < 5; op++) begin
            for (int t = 0; t < 3; t++) begin
                for (int h = 0; h < 3; h++) begin
                    for (int mi = 0; mi < 3; mi++) begin
                        int m, e_cnt, p_cnt, c_cnt, exp_m;
                        m = (mi == 0) ? 0 : (mi == 1) ? 1 : 3;
                        e_cnt = m; p_cnt = m + 2; c_cnt = m + 4;
                        wr(3'd1, 32'(h) << 16);
                        wr(3'd2, 32'(e_cnt));
                        wr(3'd3, (32'(t) << 24) | (32'(c_cnt) << 16) | 32'(p_cnt));
                        exp_m = (op == 2) ? p_cnt : (op == 4) ? c_cnt : e_cnt;
                        run_op(op, 32'h0, ns, np, nh, nb, ok);
                        chk(ns == atleast1(t), "R4 setup length", ns, atleast1(t));
                        chk(np == atleast1(exp_m), "R5 pulse length", np, atleast1(exp_m));
                        chk(nh == atleast1(h), "R4 hold length", nh, atleast1(h));
                        chk(ok, "R4 phase order", ok, 1);
                        chk(nb == atleast1(t) + atleast1(exp_m) + atleast1(h), "R3 busy length",
                            nb, atleast1(t) + atleast1(exp_m) + atleast1(h));
                        rd(3'd0, v);
                        chk(v == 0, "R8 op bits cleared", v, 0);
                    end
                end
            end
        end

        // R3 busy visible in status during an operation
        wr(3'd1, 32'h0002_0000);
        wr(3'd2, 32'd4);
        wr(3'd3, 32'h0200_0000);
        wr(3'd0, 32'h8);
        rd(3'd6, v); chk(v == 1, "R3 status busy", v, 1);
        while (busy) @(negedge clk);
        rd(3'd6, v); chk(v == 0, "R3 status idle", v, 0);

        // R6 priority: page erase + reference erase + recall -> page erase
        wr(3'd0, 32'h1D0);
        rd(3'd0, v); chk(v == 32'h110, "R6 ctrl shows winner", v, 32'h110);
        chk(fl_op == 5'b00010, "R6 fl_op winner", fl_op, 5'b00010);
        while (busy) @(negedge clk);
        rd(3'd0, v); chk(v == 32'h100, "R8 keep auto bit", v, 32'h100);
        wr(3'd0, 32'h0);

        // R6 all bits -> mass erase
        wr(3'd0, 32'hF8);
        chk(fl_op == 5'b00001, "R6 mass erase wins", fl_op, 5'b00001);
        while (busy) @(negedge clk);

        // R10 page alignment, R9 no advance for erase
        wr(3'd4, 32'h2345);
        wr(3'd5, 32'd8);
        wr(3'd0, 32'h10);
        chk(fl_addr == 16'h2000, "R10 page aligned", fl_addr, 16'h2000);
        while (busy) @(negedge clk);
        rd(3'd4, v); chk(v == 32'h2345, "R9 erase no advance", v, 32'h2345);
        wr(3'd0, 32'h8);
        chk(fl_addr == 16'h2345, "R10 mass raw addr", fl_addr, 16'h2345);
        while (busy) @(negedge clk);

        // R9 program advance, twice in a row
        wr(3'd4, 32'h0100);
        wr(3'd5, 32'd20);
        run_op(2, 32'h0, ns, np, nh, nb, ok);
        rd(3'd4, v); chk(v == 32'h0114, "R9 first advance", v, 32'h0114);
        chk(fl_addr == 16'h0114, "R9 fl_addr advance", fl_addr, 16'h0114);
        wr(3'd5, 32'd32);
        run_op(2, 32'h0, ns, np, nh, nb, ok);
        rd(3'd4, v); chk(v == 32'h0134, "R9 second advance", v, 32'h0134);
        run_op(4, 32'h0, ns, np, nh, nb, ok);
        rd(3'd4, v); chk(v == 32'h0134, "R9 recall no advance", v, 32'h0134);

        // R7 R11 busy-time writes ignored
        wr(3'd1, 32'h0003_0000);
        wr(3'd2, 32'd6);
        wr(3'd3, 32'h0300_0000);
        wr(3'd0, 32'h10);
        chk(fl_setup, "R7 in setup", fl_setup, 1);
        wr(3'd0, 32'h20);
        wr(3'd4, 32'h7777);
        wr(3'd5, 32'd3);
        chk(fl_op == 5'b00010, "R7 op unchanged", fl_op, 5'b00010);
        while (busy) @(negedge clk);
        rd(3'd0, v); chk(v == 0, "R7 no leftover request", v, 0);
        rd(3'd4, v); chk(v == 32'h0134, "R11 addr write ignored", v, 32'h0134);
        rd(3'd5, v); chk(v == 32'd32, "R11 index write ignored", v, 32);
        repeat (3) begin
            @(negedge clk);
            chk(!busy, "R7 no second operation", busy, 0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule